// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Controller

This block is the host-facing command and status front end of a network adapter. The host writes a 16-bit command word to a single port. The upper five bits select an operation and the lower eleven bits carry its argument. The same port reads back a 16-bit status word. The status word holds the selected register window, a command-in-progress flag and eight latched interrupt events, filtered through a read-zero mask. The block also keeps the receive, transmit, statistics and transceiver control flops, the receive filter and three threshold registers. It drives one interrupt request, built from the latched events and the interrupt mask.

A busy state machine has four states: `ST_IDLE`, `ST_GLB` (global reset), `ST_RXR` (receive reset) and `ST_TXR` (transmit reset). It has these transitions:
- `ST_IDLE` goes to `ST_GLB`, `ST_RXR` or `ST_TXR` when the matching reset command is accepted.
- Each of the three reset states goes back to `ST_IDLE` when its cycle counter reaches zero.

While the machine is out of `ST_IDLE`, it holds command-in-progress high and drives the matching datapath reset strobes. Every command written in that time is dropped.

Top module: `cmd_status_ctrl`

## Requirements
- R1: After reset the status word is 0x0000 and `irq`, `busy`, `rx_en`, `tx_en`, `stats_en`, `xcvr_on` and `rx_discard` are 0. `rx_filter` is 0. All three thresholds are 2047, and `rx_early_irq_on` and `tx_avail_irq_on` are 0.
- R2: Opcode 1 loads argument bits 2:0 into the window register, and the other argument bits have no effect. The window appears in status bits 15:13 from the cycle after the write. Status bits 11:8 always read 0.
- R3: A one-cycle pulse on `evt_in[k]` latches event k. Event k appears in status bit k, when that bit is visible, until it is acknowledged. Opcode 12 latches event 6. Event 0 latches when `evt_in[0]` pulses, or when any latched event among bits 7:1 is also enabled in the interrupt mask.
- R4: Opcode 13 clears each latched event whose bit is set in argument bits 7:0 and leaves the other events latched. If an event sets in the same cycle, the set wins.
- R5: Opcode 14 loads the interrupt mask from argument bits 7:0. `irq` is 1 exactly when a latched event is also enabled in that mask, starting in the cycle after the event latches.
- R6: Opcode 15 loads the read-zero mask from argument bits 7:0. A status bit 7:0 reads 0 when its mask bit is 0. The event stays latched and still drives `irq`.
- R7: The control flops are set and cleared by these opcode pairs: 4 and 3 for receive enable, 9 and 10 for transmit enable, 21 and 22 for statistics enable, and 2 and 23 for the transceiver (start and stop).
- R8: Opcodes 0, 5 and 11 raise `busy` for exactly RST_CYCLES cycles, starting in the cycle after the write. Status bit 12 equals `busy`. Any command written while busy has no effect.
- R9: Opcode 0 returns every register to its R1 value and drives `rx_rst` and `tx_rst` while busy. Opcode 5 clears `rx_en` and drives only `rx_rst`. Opcode 11 clears `tx_en` and drives only `tx_rst`.
- R10: Opcode 16 loads `rx_filter` from argument bits 3:0, with bit 0 individual, bit 1 group, bit 2 broadcast and bit 3 all. Opcodes 17, 18 and 19 load the receive early, transmit available and transmit start thresholds from argument bits 10:0. `rx_early_irq_on` and `tx_avail_irq_on` are 0 exactly when their threshold is 2047.
- R11: Opcode 8 drives `rx_discard` high for the one cycle after the write. Opcodes 6, 7, 20 and 24 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_word | input | 16 | Command word, opcode in bits 15:11, argument in bits 10:0 |
| evt_in | input | 8 | One-cycle event pulses from the datapath |
| status | output | 16 | Status word: window, busy flag, masked events |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Command in progress |
| rx_en | output | 1 | Receive enabled |
| tx_en | output | 1 | Transmit enabled |
| stats_en | output | 1 | Statistics enabled |
| xcvr_on | output | 1 | Transceiver running |
| rx_filter | output | 4 | Receive acceptance filter |
| rx_early_thr | output | 11 | Receive early threshold |
| tx_avail_thr | output | 11 | Transmit available threshold |
| tx_start_thr | output | 11 | Transmit start threshold |
| rx_early_irq_on | output | 1 | Receive early threshold interrupt armed |
| tx_avail_irq_on | output | 1 | Transmit available threshold interrupt armed |
| rx_rst | output | 1 | Receive datapath reset strobe |
| tx_rst | output | 1 | Transmit datapath reset strobe |
| rx_discard | output | 1 | Discard top receive packet pulse |

## Verification
The assertions check these properties on every cycle:
- The busy machine stays busy while its counter is nonzero.
- A write during busy leaves the window and receive enable unchanged.
- An acknowledge leaves no acknowledged bit latched unless it was set in the same cycle.
- A set event is always latched.
- `irq` never rises without a latched event.
- A global reset clears the control state.

Only the bench scenarios can show the following:
- The exact busy length.
- Event 0 following a masked event.
- The set-over-acknowledge ordering.
- Events hidden by the read-zero mask staying latched.
- Undefined opcodes changing nothing.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int EVT_W = 8;
    localparam int ARG_W = 11;
    localparam int OP_W  = 5;
    localparam int WIN_W = 3;

    localparam logic [OP_W-1:0] OP_GLOBAL_RST = 5'd0;
    localparam logic [OP_W-1:0] OP_WIN_SEL    = 5'd1;
    localparam logic [OP_W-1:0] OP_XCVR_START = 5'd2;
    localparam logic [OP_W-1:0] OP_RX_OFF     = 5'd3;
    localparam logic [OP_W-1:0] OP_RX_ON      = 5'd4;
    localparam logic [OP_W-1:0] OP_RX_RST     = 5'd5;
    localparam logic [OP_W-1:0] OP_RX_DISCARD = 5'd8;
    localparam logic [OP_W-1:0] OP_TX_ON      = 5'd9;
    localparam logic [OP_W-1:0] OP_TX_OFF     = 5'd10;
    localparam logic [OP_W-1:0] OP_TX_RST     = 5'd11;
    localparam logic [OP_W-1:0] OP_REQ_IRQ    = 5'd12;
    localparam logic [OP_W-1:0] OP_ACK        = 5'd13;
    localparam logic [OP_W-1:0] OP_SET_IMASK  = 5'd14;
    localparam logic [OP_W-1:0] OP_SET_RZMASK = 5'd15;
    localparam logic [OP_W-1:0] OP_SET_FILTER = 5'd16;
    localparam logic [OP_W-1:0] OP_SET_RXE    = 5'd17;
    localparam logic [OP_W-1:0] OP_SET_TXA    = 5'd18;
    localparam logic [OP_W-1:0] OP_SET_TXS    = 5'd19;
    localparam logic [OP_W-1:0] OP_STATS_ON   = 5'd21;
    localparam logic [OP_W-1:0] OP_STATS_OFF  = 5'd22;
    localparam logic [OP_W-1:0] OP_XCVR_STOP  = 5'd23;

    localparam int EVT_LATCH = 0;
    localparam int EVT_REQ   = 6;
    localparam logic [ARG_W-1:0] THR_OFF = {ARG_W{1'b1}};

    typedef struct packed {
        logic glb_rst;
        logic win_sel;
        logic xcvr_start;
        logic xcvr_stop;
        logic rx_off;
        logic rx_on;
        logic rx_rst;
        logic rx_discard;
        logic tx_on;
        logic tx_off;
        logic tx_rst;
        logic req_irq;
        logic ack;
        logic set_imask;
        logic set_rzmask;
        logic set_filter;
        logic set_rxe;
        logic set_txa;
        logic set_txs;
        logic stats_on;
        logic stats_off;
    } cmd_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GLB  = 2'd1,
        ST_RXR  = 2'd2,
        ST_TXR  = 2'd3
    } busy_state_e;
endpackage

// File: rtl/csc_decoder.sv
module csc_decoder
    import csc_pkg::*;
(
    input  logic                  valid,
    input  logic [OP_W+ARG_W-1:0] word,
    output cmd_dec_t              dec,
    output logic [ARG_W-1:0]      arg
);
    logic [OP_W-1:0] op;

    assign op  = word[OP_W+ARG_W-1:ARG_W];
    assign arg = word[ARG_W-1:0];

    always_comb begin
        dec = '0;
        if (valid) begin
            unique case (op)
                OP_GLOBAL_RST: dec.glb_rst    = 1'b1;
                OP_WIN_SEL:    dec.win_sel    = 1'b1;
                OP_XCVR_START: dec.xcvr_start = 1'b1;
                OP_RX_OFF:     dec.rx_off     = 1'b1;
                OP_RX_ON:      dec.rx_on      = 1'b1;
                OP_RX_RST:     dec.rx_rst     = 1'b1;
                OP_RX_DISCARD: dec.rx_discard = 1'b1;
                OP_TX_ON:      dec.tx_on      = 1'b1;
                OP_TX_OFF:     dec.tx_off     = 1'b1;
                OP_TX_RST:     dec.tx_rst     = 1'b1;
                OP_REQ_IRQ:    dec.req_irq    = 1'b1;
                OP_ACK:        dec.ack        = 1'b1;
                OP_SET_IMASK:  dec.set_imask  = 1'b1;
                OP_SET_RZMASK: dec.set_rzmask = 1'b1;
                OP_SET_FILTER: dec.set_filter = 1'b1;
                OP_SET_RXE:    dec.set_rxe    = 1'b1;
                OP_SET_TXA:    dec.set_txa    = 1'b1;
                OP_SET_TXS:    dec.set_txs    = 1'b1;
                OP_STATS_ON:   dec.stats_on   = 1'b1;
                OP_STATS_OFF:  dec.stats_off  = 1'b1;
                OP_XCVR_STOP:  dec.xcvr_stop  = 1'b1;
                default:       dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/csc_busy_fsm.sv
module csc_busy_fsm
    import csc_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_glb,
    input  logic start_rx,
    input  logic start_tx,
    output logic busy,
    output logic rx_rst,
    output logic tx_rst
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    busy_state_e      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: begin
                if (start_glb) begin
                    st_n  = ST_GLB;
                    cnt_n = CNT_LOAD;
                end else if (start_rx) begin
                    st_n  = ST_RXR;
                    cnt_n = CNT_LOAD;
                end else if (start_tx) begin
                    st_n  = ST_TXR;
                    cnt_n = CNT_LOAD;
                end
            end
            ST_GLB, ST_RXR, ST_TXR: begin
                if (cnt == '0) st_n = ST_IDLE;
                else           cnt_n = cnt - 1'b1;
            end
        endcase
    end

    always_comb begin
        busy   = (st != ST_IDLE);
        rx_rst = (st == ST_GLB) || (st == ST_RXR);
        tx_rst = (st == ST_GLB) || (st == ST_TXR);
    end

    // R8: a running reset keeps the block busy until its count runs out
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && cnt != '0) |=> busy);
endmodule

// File: rtl/csc_event_latch.sv
module csc_event_latch
    import csc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             req_set,
    input  logic             ack_en,
    input  logic [EVT_W-1:0] ack_mask,
    input  logic [EVT_W-1:0] imask,
    input  logic [EVT_W-1:0] rzmask,
    output logic [EVT_W-1:0] visible,
    output logic             irq
);
    logic [EVT_W-1:0] lat, set_vec, clr_vec;

    generate
        for (genvar i = 0; i < EVT_W; i++) begin : g_set
            if (i == EVT_LATCH) begin : g_latch_bit
                assign set_vec[i] = evt_in[i] | (|(lat[EVT_W-1:1] & imask[EVT_W-1:1]));
            end else if (i == EVT_REQ) begin : g_req_bit
                assign set_vec[i] = evt_in[i] | req_set;
            end else begin : g_plain_bit
                assign set_vec[i] = evt_in[i];
            end
        end
    endgenerate

    assign clr_vec = ack_en ? ack_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat <= '0;
        else if (clr_all) lat <= '0;
        else              lat <= (lat & ~clr_vec) | set_vec;
    end

    assign visible = lat & rzmask;
    assign irq     = |(lat & imask);

    // R4: after an acknowledge no acknowledged bit remains unless it was set together
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !clr_all) |=> ((lat & $past(ack_mask) & ~$past(set_vec)) == '0));

    // R3: every set event is latched on the next cycle
    assert_event_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0 && !clr_all) |=> (($past(set_vec) & ~lat) == '0));

    // R5: the request line needs a latched event behind it
    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lat != '0));
endmodule

// File: rtl/cmd_status_ctrl.sv
module cmd_status_ctrl
    import csc_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [OP_W+ARG_W-1:0] cmd_word,
    input  logic [EVT_W-1:0]      evt_in,
    output logic [15:0]           status,
    output logic                  irq,
    output logic                  busy,
    output logic                  rx_en,
    output logic                  tx_en,
    output logic                  stats_en,
    output logic                  xcvr_on,
    output logic [3:0]            rx_filter,
    output logic [ARG_W-1:0]      rx_early_thr,
    output logic [ARG_W-1:0]      tx_avail_thr,
    output logic [ARG_W-1:0]      tx_start_thr,
    output logic                  rx_early_irq_on,
    output logic                  tx_avail_irq_on,
    output logic                  rx_rst,
    output logic                  tx_rst,
    output logic                  rx_discard
);
    cmd_dec_t         dec;
    logic [ARG_W-1:0] arg;
    logic [WIN_W-1:0] window;
    logic [EVT_W-1:0] imask, rzmask, visible;
    logic             accept;

    assign accept = cmd_wr && !busy;

    csc_decoder u_dec (
        .valid (accept),
        .word  (cmd_word),
        .dec   (dec),
        .arg   (arg)
    );

    csc_busy_fsm #(.RST_CYCLES(RST_CYCLES)) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_glb (dec.glb_rst),
        .start_rx  (dec.rx_rst),
        .start_tx  (dec.tx_rst),
        .busy      (busy),
        .rx_rst    (rx_rst),
        .tx_rst    (tx_rst)
    );

    csc_event_latch u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (dec.glb_rst),
        .evt_in   (evt_in),
        .req_set  (dec.req_irq),
        .ack_en   (dec.ack),
        .ack_mask (arg[EVT_W-1:0]),
        .imask    (imask),
        .rzmask   (rzmask),
        .visible  (visible),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            window       <= '0;
            rx_en        <= 1'b0;
            tx_en        <= 1'b0;
            stats_en     <= 1'b0;
            xcvr_on      <= 1'b0;
            imask        <= '0;
            rzmask       <= '0;
            rx_filter    <= '0;
            rx_early_thr <= THR_OFF;
            tx_avail_thr <= THR_OFF;
            tx_start_thr <= THR_OFF;
            rx_discard   <= 1'b0;
        end else if (dec.glb_rst) begin
            window       <= '0;
            rx_en        <= 1'b0;
            tx_en        <= 1'b0;
            stats_en     <= 1'b0;
            xcvr_on      <= 1'b0;
            imask        <= '0;
            rzmask       <= '0;
            rx_filter    <= '0;
            rx_early_thr <= THR_OFF;
            tx_avail_thr <= THR_OFF;
            tx_start_thr <= THR_OFF;
            rx_discard   <= 1'b0;
        end else begin
            rx_discard <= dec.rx_discard;
            if (dec.win_sel)                window   <= arg[WIN_W-1:0];
            if (dec.rx_on)                  rx_en    <= 1'b1;
            if (dec.rx_off || dec.rx_rst)   rx_en    <= 1'b0;
            if (dec.tx_on)                  tx_en    <= 1'b1;
            if (dec.tx_off || dec.tx_rst)   tx_en    <= 1'b0;
            if (dec.stats_on)               stats_en <= 1'b1;
            if (dec.stats_off)              stats_en <= 1'b0;
            if (dec.xcvr_start)             xcvr_on  <= 1'b1;
            if (dec.xcvr_stop)              xcvr_on  <= 1'b0;
            if (dec.set_imask)              imask    <= arg[EVT_W-1:0];
            if (dec.set_rzmask)             rzmask   <= arg[EVT_W-1:0];
            if (dec.set_filter)             rx_filter <= arg[3:0];
            if (dec.set_rxe)                rx_early_thr <= arg;
            if (dec.set_txa)                tx_avail_thr <= arg;
            if (dec.set_txs)                tx_start_thr <= arg;
        end
    end

    assign rx_early_irq_on = (rx_early_thr != THR_OFF);
    assign tx_avail_irq_on = (tx_avail_thr != THR_OFF);
    assign status = {window, busy, 4'b0000, visible};

    // R8: a write while busy leaves window and receive enable untouched
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ($stable(window) && $stable(rx_en)));

    // R7: an accepted receive disable leaves receive off
    assert_rx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec.rx_off |=> !rx_en);

    // R9: global reset brings the control state back to its reset values
    assert_glb_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec.glb_rst |=> (!rx_en && !tx_en && !stats_en && window == '0 && !irq));
endmodule

// File: tb/tb_cmd_status_ctrl.sv
module tb_cmd_status_ctrl;
    localparam int RC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  evt_in = '0;
    logic [15:0] status;
    logic        irq, busy, rx_en, tx_en, stats_en, xcvr_on;
    logic [3:0]  rx_filter;
    logic [10:0] rx_early_thr, tx_avail_thr, tx_start_thr;
    logic        rx_early_irq_on, tx_avail_irq_on, rx_rst, tx_rst, rx_discard;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmd_status_ctrl #(.RST_CYCLES(RC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .evt_in(evt_in), .status(status), .irq(irq), .busy(busy),
        .rx_en(rx_en), .tx_en(tx_en), .stats_en(stats_en), .xcvr_on(xcvr_on),
        .rx_filter(rx_filter), .rx_early_thr(rx_early_thr),
        .tx_avail_thr(tx_avail_thr), .tx_start_thr(tx_start_thr),
        .rx_early_irq_on(rx_early_irq_on), .tx_avail_irq_on(tx_avail_irq_on),
        .rx_rst(rx_rst), .tx_rst(tx_rst), .rx_discard(rx_discard)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] op, input logic [10:0] a);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = {op, a};
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 16'h0000);
        chk("R1 flops", {irq, busy, rx_en, tx_en, stats_en, xcvr_on, rx_discard}, 16'h0);
        chk("R1 filter", {12'h0, rx_filter}, 16'h0);
        chk("R1 rxe thr", {5'h0, rx_early_thr}, 16'h07FF);
        chk("R1 txa thr", {5'h0, tx_avail_thr}, 16'h07FF);
        chk("R1 txs thr", {5'h0, tx_start_thr}, 16'h07FF);
        chk("R1 thr on", {14'h0, rx_early_irq_on, tx_avail_irq_on}, 16'h0);

        wr(5'd15, 11'h0FF);
        // R2 window sweep with noise in the upper argument bits
        for (int w = 0; w < 8; w++) begin
            wr(5'd1, 11'(((w * 8'h5B) << 3) & 11'h7F8) | 11'(w));
            chk("R2 window", status, {3'(w), 13'h0});
        end
        wr(5'd1, 11'h000);

        // R3 / R4 per-event latch and acknowledge sweep
        for (int k = 1; k < 8; k++) begin
            pulse(8'(1 << k));
            chk("R3 latch", status, {8'h00, 8'(1 << k)});
            wr(5'd13, 11'(~(1 << k) & 8'hFF));
            chk("R4 ack others", status, {8'h00, 8'(1 << k)});
            wr(5'd13, 11'(1 << k));
            chk("R4 ack own", status, 16'h0000);
        end
        wr(5'd12, 11'h000);
        chk("R3 request", status, 16'h0040);
        wr(5'd13, 11'h040);

        // R5 interrupt mask sweep and event 0 follow-up
        for (int k = 1; k < 8; k++) begin
            wr(5'd14, 11'(1 << k));
            chk("R5 irq idle", {15'h0, irq}, 16'h0);
            pulse(8'(1 << k));
            chk("R5 irq on", {15'h0, irq}, 16'h1);
            @(negedge clk);
            chk("R3 bit0", status, {8'h00, 8'((1 << k) | 1)});
            wr(5'd13, 11'(1 << k));
            wr(5'd13, 11'h001);
            chk("R5 irq off", {irq, status[14:0]}, 16'h0);
        end
        wr(5'd14, 11'h000);

        // R4 set wins over same-cycle acknowledge
        @(negedge clk);
        evt_in = 8'h08; cmd_wr = 1'b1; cmd_word = {5'd13, 11'h008};
        @(negedge clk);
        evt_in = 8'h00; cmd_wr = 1'b0;
        chk("R4 set wins", status, 16'h0008);
        wr(5'd13, 11'h0FF);
        chk("R4 cleared", status, 16'h0000);

        // R6 read-zero mask hides but keeps the event
        wr(5'd14, 11'h010);
        wr(5'd15, 11'h0EE);
        pulse(8'h10);
        chk("R6 hidden", status, 16'h0000);
        chk("R6 irq", {15'h0, irq}, 16'h1);
        wr(5'd15, 11'h0FF);
        chk("R6 shown", status, 16'h0011);
        wr(5'd13, 11'h010);
        wr(5'd13, 11'h001);
        wr(5'd14, 11'h000);
        chk("R6 clean", {irq, status[14:0]}, 16'h0);

        // R7 control flops
        wr(5'd4, 11'h7FF);  chk("R7 rx on", {15'h0, rx_en}, 16'h1);
        wr(5'd3, 11'h000);  chk("R7 rx off", {15'h0, rx_en}, 16'h0);
        wr(5'd9, 11'h000);  chk("R7 tx on", {15'h0, tx_en}, 16'h1);
        wr(5'd10, 11'h000); chk("R7 tx off", {15'h0, tx_en}, 16'h0);
        wr(5'd21, 11'h000); chk("R7 stats on", {15'h0, stats_en}, 16'h1);
        wr(5'd22, 11'h000); chk("R7 stats off", {15'h0, stats_en}, 16'h0);
        wr(5'd2, 11'h000);  chk("R7 xcvr on", {15'h0, xcvr_on}, 16'h1);
        wr(5'd23, 11'h000); chk("R7 xcvr off", {15'h0, xcvr_on}, 16'h0);

        // R10 filter and thresholds
        wr(5'd16, 11'h7F5); chk("R10 filter", {12'h0, rx_filter}, 16'h0005);
        wr(5'd17, 11'd100);
        chk("R10 rxe", {5'h0, rx_early_thr}, 16'd100);
        chk("R10 rxe on", {15'h0, rx_early_irq_on}, 16'h1);
        wr(5'd18, 11'd2046);
        chk("R10 txa on", {15'h0, tx_avail_irq_on}, 16'h1);
        wr(5'd18, 11'd2047);
        chk("R10 txa off", {15'h0, tx_avail_irq_on}, 16'h0);
        wr(5'd19, 11'd300);
        chk("R10 txs", {5'h0, tx_start_thr}, 16'd300);

        // R11 discard pulse and undefined opcodes
        wr(5'd8, 11'h000);
        chk("R11 discard hi", {15'h0, rx_discard}, 16'h1);
        @(negedge clk);
        chk("R11 discard lo", {15'h0, rx_discard}, 16'h0);
        wr(5'd1, 11'h005);
        wr(5'd4, 11'h000);
        for (int op = 20; op < 32; op++) begin
            if (op == 21 || op == 22 || op == 23) continue;
            wr(5'(op), 11'h7FF);
        end
        wr(5'd6, 11'h7FF);
        wr(5'd7, 11'h7FF);
        chk("R11 undef status", status, 16'hA0FF & 16'hA000);
        chk("R11 undef flops", {irq, rx_en, tx_en, stats_en, xcvr_on, rx_discard, rx_filter},
            16'b0_1_0_0_0_0_0101);
        chk("R11 undef thr", {5'h0, tx_start_thr}, 16'd300);

        // R8 / R9 receive reset
        wr(5'd5, 11'h000);
        for (int c = 0; c < RC; c++) begin
            chk("R8 rx busy", {busy, status[12], rx_rst, tx_rst}, 16'b1110);
            if (c == 1) begin
                cmd_wr = 1'b1; cmd_word = {5'd1, 11'h002};
                @(negedge clk);
                cmd_wr = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk("R8 rx done", {busy, rx_rst}, 16'h0);
        chk("R8 ignored", status, 16'hA000);
        chk("R9 rx cleared", {15'h0, rx_en}, 16'h0);

        // R9 transmit reset
        wr(5'd9, 11'h000);
        wr(5'd11, 11'h000);
        chk("R9 tx strobe", {busy, rx_rst, tx_rst}, 16'b101);
        repeat (RC) @(negedge clk);
        chk("R9 tx done", {busy, tx_rst, tx_en}, 16'h0);

        // R9 global reset
        wr(5'd21, 11'h000);
        wr(5'd14, 11'h004);
        pulse(8'h04);
        wr(5'd0, 11'h000);
        for (int c = 0; c < RC; c++) begin
            chk("R9 glb busy", {busy, rx_rst, tx_rst}, 16'b111);
            @(negedge clk);
        end
        chk("R9 glb status", status, 16'h0000);
        chk("R9 glb flops", {irq, busy, rx_en, tx_en, stats_en, xcvr_on, rx_filter}, 16'h0);
        chk("R9 glb thr", {5'h0, tx_start_thr}, 16'h07FF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule